// File: doc/BRIEF.md
# Byte-Lane Width Adapter for a 32-bit Memory

This block lets a master that works with 16-bit or 8-bit items use a memory that stores 32-bit words and has a separate active-low enable for each byte lane. A static organization input picks 32-bit, 16-bit or 8-bit access. The low master address bits that fall below the word boundary choose which byte lanes are enabled. The remaining bits form the word address. Lanes that are not enabled stay in standby, so they neither accept writes nor drive the shared data bus.

On writes, the narrow item is copied onto every lane, so each enabled lane sees the right byte. On reads, the returned 32-bit word is shifted so that the selected lanes land at bit 0. Bits above the item width are zero. The request and write strobes pass straight through to a word-oriented memory controller. The completion strobe and the aligned read data come back one register later. The lane offset used for alignment is the one from the most recent request.

Top module: `lane_width_adapter`

## Requirements
- R1: With organization code 0 (32-bit), the word address is master address bits 16:0, and during a request the lane enables are the inverse of the master byte mask (mask bit n high enables lane n, so enable n is driven low).
- R2: With organization code 1 (16-bit), the word address is master address bits 17:1. Master address bit 0 low enables lanes 0 and 1 (enable vector 4'b1100), and high enables lanes 2 and 3 (4'b0011). The byte mask has no effect.
- R3: With organization code 2 (8-bit), the word address is master address bits 18:2, and exactly the lane numbered by master address bits 1:0 has its enable low. The byte mask has no effect.
- R4: While no request is present, all four lane enables are high (4'b1111).
- R5: Memory write data is the master write data unchanged in 32-bit mode, two copies of bits 15:0 in 16-bit mode, and four copies of bits 7:0 in 8-bit mode.
- R6: In the cycle after the memory completion strobe, the read data holds the selected lanes shifted down to bit 0, with all bits above the item width at zero. The lane offset comes from the request active in the completion cycle, or else from the most recent earlier request.
- R7: The memory request and write strobes equal the master ones in the same cycle, and the master completion strobe is the memory completion strobe delayed by one clock.
- R8: While the synchronous active-low reset is asserted at a clock edge, the completion strobe and the read data become zero.
- R9: Organization code 3 behaves exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| org_mode_i | input | 2 | Organization: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = 32-bit |
| m_req_i | input | 1 | Master access request |
| m_we_i | input | 1 | Master write strobe |
| m_addr_i | input | 19 | Master item address |
| m_mask_i | input | 4 | Byte mask, used in 32-bit mode only |
| m_wdata_i | input | 32 | Master write data, right-aligned |
| m_done_o | output | 1 | Access complete, read data valid |
| m_rdata_o | output | 32 | Right-aligned read data |
| mem_req_o | output | 1 | Request to the memory controller |
| mem_we_o | output | 1 | Write strobe to the memory controller |
| mem_addr_o | output | 17 | Memory word address |
| mem_lane_en_n_o | output | 4 | Active-low byte-lane enables |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| mem_done_i | input | 1 | Completion from the memory controller |
| mem_rdata_i | input | 32 | 32-bit word returned by the memory |

## Verification
The bench builds the block with its default parameters: a 17-bit word address and four 8-bit lanes. In this build every organization code and every lane offset can be reached. The address vectors include all-ones addresses, which show that the top master bit reaches the word address only in 8-bit mode. Nonzero masks in the narrow modes show that the mask is ignored. A read whose completion comes after the request has dropped exercises the held lane offset.

// File: rtl/lwa_pkg.sv
// Shared types for the byte-lane width adapter.
// Assumes the memory has four byte lanes and the mode input is static.
package lwa_pkg;
    typedef enum logic [1:0] {
        ORG_X32  = 2'd0,
        ORG_X16  = 2'd1,
        ORG_X8   = 2'd2,
        ORG_X32B = 2'd3
    } org_e;
endpackage

// File: rtl/lwa_addr_map.sv
// Address map: splits the master item address into a memory word
// address and active-low lane enables, and reports the byte offset of
// the selected item inside the word. Assumes LANES = 4.
module lwa_addr_map
    import lwa_pkg::*;
#(
    parameter int WORD_AW = 17,
    parameter int LANES   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  org_e                       org,
    input  logic                       req,
    input  logic [WORD_AW+$clog2(LANES)-1:0] addr,
    input  logic [LANES-1:0]           mask,
    output logic [WORD_AW-1:0]         word_addr,
    output logic [LANES-1:0]           lane_en_n,
    output logic [$clog2(LANES)-1:0]   lane_off
);
    localparam int OFF_W = $clog2(LANES);
    localparam int MST_AW = WORD_AW + OFF_W;

    logic [1:0]       shamt;
    logic [MST_AW-1:0] shifted;

    // Picks how many low address bits address lanes, and the lane offset.
    always_comb begin
        unique case (org)
            ORG_X16: begin
                shamt    = 2'd1;
                lane_off = {addr[0], 1'b0};
            end
            ORG_X8: begin
                shamt    = 2'd2;
                lane_off = addr[OFF_W-1:0];
            end
            default: begin
                shamt    = 2'd0;
                lane_off = '0;
            end
        endcase
    end

    // Drops the lane-select bits to form the word address.
    always_comb begin
        shifted   = addr >> shamt;
        word_addr = shifted[WORD_AW-1:0];
    end

    // Builds the enables per lane; idle lanes stay in standby.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            if (!req) begin
                lane_en_n[l] = 1'b1;
            end else begin
                unique case (org)
                    ORG_X16: lane_en_n[l] = ((l / 2) != int'(addr[0]));
                    ORG_X8:  lane_en_n[l] = (l != int'(addr[OFF_W-1:0]));
                    default: lane_en_n[l] = ~mask[l];
                endcase
            end
        end
    end

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (lane_en_n == '1)); // R4
    AST_X8_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && org == ORG_X8) |-> ($countones(~lane_en_n) == 1)); // R3
    AST_X16_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (req && org == ORG_X16) |-> ($countones(~lane_en_n) == 2)); // R2
endmodule

// File: rtl/lwa_wr_steer.sv
// Write steering: copies the narrow item onto every lane so that the
// enabled lanes always see the right bytes. Assumes LANES = 4.
module lwa_wr_steer
    import lwa_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  org_e                      org,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   lane_wdata
);
    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            // Chooses the source lane for lane l from the organization.
            always_comb begin
                unique case (org)
                    ORG_X16: lane_wdata[l*LANE_W +: LANE_W] = wdata[(l%2)*LANE_W +: LANE_W];
                    ORG_X8:  lane_wdata[l*LANE_W +: LANE_W] = wdata[LANE_W-1:0];
                    default: lane_wdata[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/lwa_rd_align.sv
// Read alignment: keeps the lane offset of the latest request, and on
// completion registers the returned word shifted to bit 0 with the
// bits above the item width cleared. Assumes LANES = 4.
module lwa_rd_align
    import lwa_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  org_e                      org,
    input  logic                      req,
    input  logic [$clog2(LANES)-1:0]  lane_off,
    input  logic                      mem_done,
    input  logic [LANES*LANE_W-1:0]   mem_rdata,
    output logic                      done,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int OFF_W  = $clog2(LANES);
    localparam int DATA_W = LANES * LANE_W;

    logic [OFF_W-1:0]  held_off;
    logic [OFF_W-1:0]  use_off;
    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] aligned;

    // Remembers the lane offset of the most recent request.
    always_ff @(posedge clk) begin
        if (!rst_n)   held_off <= '0;
        else if (req) held_off <= lane_off;
    end

    // Shifts the selected lanes down and clears the unused upper bits.
    always_comb begin
        use_off = req ? lane_off : held_off;
        unique case (org)
            ORG_X16: keep = DATA_W'({(2*LANE_W){1'b1}});
            ORG_X8:  keep = DATA_W'({LANE_W{1'b1}});
            default: keep = '1;
        endcase
        aligned = (mem_rdata >> (int'(use_off) * LANE_W)) & keep;
    end

    // Registers the completion strobe and aligned data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            rdata <= '0;
        end else begin
            done <= mem_done;
            if (mem_done) rdata <= aligned;
        end
    end

    AST_DONE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_done |=> done); // R7
    AST_X8_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && org == ORG_X8 && $past(org) == ORG_X8) |-> (rdata[DATA_W-1:LANE_W] == '0)); // R6
endmodule

// File: rtl/lane_width_adapter.sv
// Top of the byte-lane width adapter: presents a 32-bit memory with
// per-lane enables as a 32-, 16- or 8-bit wide store. Assumes the
// organization input changes only while no access is in flight.
module lane_width_adapter
    import lwa_pkg::*;
#(
    parameter int WORD_AW = 17,
    parameter int LANES   = 4,
    parameter int LANE_W  = 8,
    localparam int OFF_W  = $clog2(LANES),
    localparam int MST_AW = WORD_AW + OFF_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        org_mode_i,
    input  logic              m_req_i,
    input  logic              m_we_i,
    input  logic [MST_AW-1:0] m_addr_i,
    input  logic [LANES-1:0]  m_mask_i,
    input  logic [DATA_W-1:0] m_wdata_i,
    output logic              m_done_o,
    output logic [DATA_W-1:0] m_rdata_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_AW-1:0] mem_addr_o,
    output logic [LANES-1:0]  mem_lane_en_n_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_done_i,
    input  logic [DATA_W-1:0] mem_rdata_i
);
    org_e             org;
    logic [OFF_W-1:0] lane_off;

    // Decodes the organization code; code 3 acts as 32-bit.
    always_comb org = org_e'(org_mode_i);

    // Passes the request and write strobes straight through.
    always_comb begin
        mem_req_o = m_req_i;
        mem_we_o  = m_we_i;
    end

    lwa_addr_map #(.WORD_AW(WORD_AW), .LANES(LANES)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .org       (org),
        .req       (m_req_i),
        .addr      (m_addr_i),
        .mask      (m_mask_i),
        .word_addr (mem_addr_o),
        .lane_en_n (mem_lane_en_n_o),
        .lane_off  (lane_off)
    );

    lwa_wr_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
        .org        (org),
        .wdata      (m_wdata_i),
        .lane_wdata (mem_wdata_o)
    );

    lwa_rd_align #(.LANES(LANES), .LANE_W(LANE_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .org       (org),
        .req       (m_req_i),
        .lane_off  (lane_off),
        .mem_done  (mem_done_i),
        .mem_rdata (mem_rdata_i),
        .done      (m_done_o),
        .rdata     (m_rdata_o)
    );

    AST_REQ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o == m_req_i) && (mem_we_o == m_we_i)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!m_done_o && m_rdata_o == '0)); // R8
endmodule

// File: tb/lane_width_adapter_test.sv
module lane_width_adapter_test;
    typedef struct packed {
        logic [1:0]  mode;
        logic [18:0] addr;
        logic [3:0]  mask;
        logic [31:0] wd;
        logic [16:0] exp_addr;
        logic [3:0]  exp_en;
        logic [31:0] exp_wd;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 19'h12345, 4'b1010, 32'hDEADBEEF, 17'h12345, 4'b0101, 32'hDEADBEEF}, // R1
        '{2'd0, 19'h7FFFF, 4'b1111, 32'h01234567, 17'h1FFFF, 4'b0000, 32'h01234567}, // R1
        '{2'd1, 19'h00003, 4'b0000, 32'h12345A5A, 17'h00001, 4'b0011, 32'h5A5A5A5A}, // R2
        '{2'd1, 19'h3FFFE, 4'b1111, 32'h0000BEEF, 17'h1FFFF, 4'b1100, 32'hBEEFBEEF}, // R2
        '{2'd2, 19'h00006, 4'b0000, 32'hFFFFFF3C, 17'h00001, 4'b1011, 32'h3C3C3C3C}, // R3
        '{2'd2, 19'h7FFFF, 4'b0000, 32'h00000011, 17'h1FFFF, 4'b0111, 32'h11111111}, // R3
        '{2'd2, 19'h00004, 4'b1111, 32'h000000A5, 17'h00001, 4'b1110, 32'hA5A5A5A5}, // R3
        '{2'd2, 19'h00001, 4'b0000, 32'h00000077, 17'h00000, 4'b1101, 32'h77777777}, // R3
        '{2'd3, 19'h12345, 4'b0110, 32'hCAFEF00D, 17'h12345, 4'b1001, 32'hCAFEF00D}, // R9
        '{2'd3, 19'h40000, 4'b0000, 32'h00000000, 17'h00000, 4'b1111, 32'h00000000}  // R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  org_mode_i = 2'd0;
    logic        m_req_i = 1'b0;
    logic        m_we_i = 1'b0;
    logic [18:0] m_addr_i = '0;
    logic [3:0]  m_mask_i = '0;
    logic [31:0] m_wdata_i = '0;
    logic        m_done_o;
    logic [31:0] m_rdata_o;
    logic        mem_req_o;
    logic        mem_we_o;
    logic [16:0] mem_addr_o;
    logic [3:0]  mem_lane_en_n_o;
    logic [31:0] mem_wdata_o;
    logic        mem_done_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    lane_width_adapter uut (
        .clk(clk), .rst_n(rst_n), .org_mode_i(org_mode_i),
        .m_req_i(m_req_i), .m_we_i(m_we_i), .m_addr_i(m_addr_i),
        .m_mask_i(m_mask_i), .m_wdata_i(m_wdata_i),
        .m_done_o(m_done_o), .m_rdata_o(m_rdata_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_lane_en_n_o(mem_lane_en_n_o), .mem_wdata_o(mem_wdata_o),
        .mem_done_i(mem_done_i), .mem_rdata_i(mem_rdata_i)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One read: request with completion in the same cycle, checked after the edge.
    task automatic rd_same(input logic [1:0] mode, input logic [18:0] a,
                           input logic [31:0] word, input logic [31:0] exp, input string tag);
        @(negedge clk);
        org_mode_i = mode; m_req_i = 1'b1; m_we_i = 1'b0; m_addr_i = a;
        mem_done_i = 1'b1; mem_rdata_i = word;
        @(posedge clk); #1;
        chk({tag, " done"}, {31'd0, m_done_o}, 32'd1);
        chk({tag, " rdata"}, m_rdata_o, exp);
        @(negedge clk);
        m_req_i = 1'b0; mem_done_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R8: reset state
        repeat (2) @(posedge clk);
        #1;
        chk("R8 done in reset", {31'd0, m_done_o}, 32'd0);
        chk("R8 rdata in reset", m_rdata_o, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R4: idle standby
        @(negedge clk); m_req_i = 1'b0; m_mask_i = 4'hF; org_mode_i = 2'd0;
        #2;
        chk("R4 idle enables", {28'd0, mem_lane_en_n_o}, 32'hF);

        // Vector table: address map, enables and write replication
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            org_mode_i = VECS[i].mode; m_req_i = 1'b1; m_we_i = 1'b1;
            m_addr_i = VECS[i].addr; m_mask_i = VECS[i].mask; m_wdata_i = VECS[i].wd;
            #2;
            chk($sformatf("R1/R2/R3/R9 word addr v%0d", i), {15'd0, mem_addr_o}, {15'd0, VECS[i].exp_addr});
            chk($sformatf("R1/R2/R3/R9 lane en v%0d", i), {28'd0, mem_lane_en_n_o}, {28'd0, VECS[i].exp_en});
            chk($sformatf("R5 wdata v%0d", i), mem_wdata_o, VECS[i].exp_wd);
            chk($sformatf("R7 req/we pass v%0d", i), {30'd0, mem_req_o, mem_we_o}, 32'd3);
        end
        @(negedge clk); m_req_i = 1'b0; m_we_i = 1'b0;
        #2;
        chk("R7 req drop", {31'd0, mem_req_o}, 32'd0);
        chk("R4 enables after drop", {28'd0, mem_lane_en_n_o}, 32'hF);

        // R6: read alignment in each mode
        rd_same(2'd0, 19'h00010, 32'hA1B2C3D4, 32'hA1B2C3D4, "R6 x32");
        rd_same(2'd1, 19'h00001, 32'hA1B2C3D4, 32'h0000A1B2, "R6 x16 upper");
        rd_same(2'd1, 19'h00000, 32'hA1B2C3D4, 32'h0000C3D4, "R6 x16 lower");
        rd_same(2'd2, 19'h00000, 32'hA1B2C3D4, 32'h000000D4, "R6 x8 lane0");
        rd_same(2'd2, 19'h00002, 32'hA1B2C3D4, 32'h000000B2, "R6 x8 lane2");
        rd_same(2'd2, 19'h00003, 32'hA1B2C3D4, 32'h000000A1, "R6 x8 lane3");

        // R7: done falls one cycle after the memory strobe falls
        @(posedge clk); #1;
        chk("R7 done low", {31'd0, m_done_o}, 32'd0);

        // R6: completion after request dropped uses held offset
        @(negedge clk);
        org_mode_i = 2'd2; m_req_i = 1'b1; m_addr_i = 19'h00005;
        @(negedge clk);
        m_req_i = 1'b0; m_addr_i = 19'h00000;
        mem_done_i = 1'b1; mem_rdata_i = 32'h11223344;
        @(posedge clk); #1;
        chk("R6 held offset", m_rdata_o, 32'h00000033);
        chk("R7 done late", {31'd0, m_done_o}, 32'd1);
        @(negedge clk); mem_done_i = 1'b0;

        // R8: reset mid-operation clears outputs
        @(negedge clk); rst_n = 1'b0; mem_done_i = 1'b1;
        @(posedge clk); #1;
        chk("R8 done after reset", {31'd0, m_done_o}, 32'd0);
        chk("R8 rdata after reset", m_rdata_o, 32'd0);
        @(negedge clk); rst_n = 1'b1; mem_done_i = 1'b0;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule